// File: doc/BRIEF.md
# PHY Control-Register Port Master

This block is a hardware engine for a PHY's internal control-register port, a slow serial-style interface. Without it, software would drive that port by toggling its pins one at a time. A client issues one command on a simple request interface: a direction flag, a 16-bit register address and 16-bit write data. The engine then runs the whole port transaction by itself. It produces a slow port clock whose high and low phases each last a set number of system clock cycles. It drives the select, address, write-data and two enable lines in a fixed order, and it samples the port's acknowledge and its 32-bit returned data word.

Every access begins with a fixed burst of free-running port clock pulses. The engine then sets up select and address (and write data), strobes one enable across a single port clock pulse, and polls the acknowledge. After each poll that finds no acknowledge, it sends one extra port clock pulse. When the acknowledge arrives, the engine ends with a one-cycle done pulse; for a read, the captured data is returned with it. When the poll budget is used up, the engine ends with a one-cycle timeout pulse instead. Only one command can be in flight. A busy flag covers it, and commands presented while busy are dropped.

Top module: `phyport_master`

## Requirements
- R1: Each access starts with exactly PRE_PULSES (default 100) complete port clock pulses, each high then low, sent while select is low. Select only changes while the port clock is low.
- R2: The high phase and the low phase of every port clock pulse each last PHASE_CYCLES system clock cycles (default 2).
- R3: Select is raised before the address lines change. For a write, the write data is already on its lines, with select high, when the write enable rises.
- R4: A write raises only the write enable and a read raises only the read enable. The enable rises while the port clock is low, exactly one port clock pulse is issued while it is high, and then it is cleared.
- R5: After the enable is cleared, the acknowledge is sampled. Each sample that finds it low and still has budget left is followed by exactly one extra port clock pulse before the next sample.
- R6: After MAX_POLLS samples (default 100000) without an acknowledge, the access ends with a one-cycle rsp_timeout pulse and no rsp_done. In that case MAX_POLLS-1 extra pulses will have been sent. An acknowledge found on the last allowed sample still ends in rsp_done.
- R7: For a read, rsp_rdata takes bits 31:16 of the returned port word when the acknowledge is seen. Bits 15:0 have no effect on it.
- R8: busy is high from the cycle after a request is accepted until the cycle of its rsp_done or rsp_timeout pulse. A request presented while busy is high is ignored and produces no port access and no response.
- R9: A synchronous reset, including one in the middle of an access, drives the port clock low, clears select, both enables, busy, rsp_done and rsp_timeout, and leaves the engine idle.
- R10: A write delivers its address and data to the port during its enable strobe, so that a later read of that address returns the written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request strobe, taken when busy is low |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Port register address |
| req_wdata | input | DATA_W | Write data |
| busy | output | 1 | Access in progress |
| rsp_done | output | 1 | One-cycle pulse: acknowledge received |
| rsp_timeout | output | 1 | One-cycle pulse: poll budget exhausted |
| rsp_rdata | output | DATA_W | Read data, valid with rsp_done of a read |
| phy_clk | output | 1 | Slow port clock |
| phy_sel | output | 1 | Port select |
| phy_addr | output | ADDR_W | Port address lines |
| phy_wdata | output | DATA_W | Port write-data lines |
| phy_rd_en | output | 1 | Port read enable |
| phy_wr_en | output | 1 | Port write enable |
| phy_ack | input | 1 | Port acknowledge |
| phy_rdword | input | PORT_W | Port returned data word |

## Verification
The bench keeps the default PRE_PULSES of 100, so the full preamble length is checked on every access. It builds the engine with PHASE_CYCLES set to 3, which shows that both phases stretch with the parameter rather than being fixed at two cycles. It also sets MAX_POLLS to 8. With that value, an acknowledge that arrives exactly on the last allowed sample can be placed beside one that never arrives, so both sides of the timeout boundary are exercised in a short run. A responder model supplies a programmable acknowledge delay and fills the low half of each returned word with values unrelated to the stored data.

// File: rtl/phyport_pkg.sv
package phyport_pkg;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_PRE,
      ST_SEL,
      ST_ADDR,
      ST_DATA,
      ST_EN,
      ST_GO,
      ST_STRB,
      ST_POLL,
      ST_PCLK
   } phyport_state_e;

endpackage

// File: rtl/phyport_clk_burst.sv
// Produces a train of n_pulses port clock pulses, each PHASE_CYCLES high
// followed by PHASE_CYCLES low; 'last' marks the final low-phase cycle.
module phyport_clk_burst #(
   parameter int PHASE_CYCLES = 2,
   parameter int MAX_PULSES   = 100,
   localparam int NW          = $clog2(MAX_PULSES + 1)
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          start,
   input  logic [NW-1:0] n_pulses,
   output logic          pclk,
   output logic          last
);

   logic          active_q;
   logic          pclk_q;
   logic [NW-1:0] left_q;
   logic          phase_end;

   if (PHASE_CYCLES < 1) begin : g_bad_phase
      $error("phyport_clk_burst: PHASE_CYCLES must be at least 1");
   end
   if (MAX_PULSES < 1) begin : g_bad_pulses
      $error("phyport_clk_burst: MAX_PULSES must be at least 1");
   end

   if (PHASE_CYCLES == 1) begin : g_single
      assign phase_end = 1'b1;
   end else begin : g_multi
      localparam int CW = $clog2(PHASE_CYCLES);
      logic [CW-1:0] ph_q;
      assign phase_end = (ph_q == CW'(PHASE_CYCLES - 1));
      always_ff @(posedge clk) begin
         if (rst || !active_q || phase_end) ph_q <= '0;
         else                               ph_q <= ph_q + 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         active_q <= 1'b0;
         pclk_q   <= 1'b0;
         left_q   <= '0;
      end else if (!active_q) begin
         if (start) begin
            active_q <= 1'b1;
            pclk_q   <= 1'b1;
            left_q   <= n_pulses - 1'b1;
         end
      end else if (phase_end) begin
         if (pclk_q) begin
            pclk_q <= 1'b0;
         end else if (left_q == '0) begin
            active_q <= 1'b0;
         end else begin
            left_q <= left_q - 1'b1;
            pclk_q <= 1'b1;
         end
      end
   end

   assign pclk = pclk_q;
   assign last = active_q && !pclk_q && phase_end && (left_q == '0);

endmodule

// File: rtl/phyport_poll_ctr.sv
// Counts acknowledge samples that missed; 'expired' flags the last allowed one.
module phyport_poll_ctr #(
   parameter int MAX_POLLS = 100000,
   localparam int CW       = $clog2(MAX_POLLS)
) (
   input  logic clk,
   input  logic rst,
   input  logic clr,
   input  logic miss,
   output logic expired
);

   logic [CW-1:0] cnt_q;

   if (MAX_POLLS < 2) begin : g_bad_polls
      $error("phyport_poll_ctr: MAX_POLLS must be at least 2");
   end

   always_ff @(posedge clk) begin
      if (rst || clr) cnt_q <= '0;
      else if (miss)  cnt_q <= cnt_q + 1'b1;
   end

   assign expired = (cnt_q == CW'(MAX_POLLS - 1));

endmodule

// File: rtl/phyport_master.sv
module phyport_master
   import phyport_pkg::*;
#(
   parameter int ADDR_W       = 16,
   parameter int DATA_W       = 16,
   parameter int PORT_W       = 32,
   parameter int PRE_PULSES   = 100,
   parameter int PHASE_CYCLES = 2,
   parameter int MAX_POLLS    = 100000
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              busy,
   output logic              rsp_done,
   output logic              rsp_timeout,
   output logic [DATA_W-1:0] rsp_rdata,
   output logic              phy_clk,
   output logic              phy_sel,
   output logic [ADDR_W-1:0] phy_addr,
   output logic [DATA_W-1:0] phy_wdata,
   output logic              phy_rd_en,
   output logic              phy_wr_en,
   input  logic              phy_ack,
   input  logic [PORT_W-1:0] phy_rdword
);

   localparam int NW = $clog2(PRE_PULSES + 1);

   if (PORT_W < 2 * DATA_W) begin : g_bad_port
      $error("phyport_master: PORT_W must hold the data field in its upper half");
   end

   phyport_state_e    st_q;
   logic              cmd_wr_q;
   logic [ADDR_W-1:0] cmd_addr_q;
   logic [DATA_W-1:0] cmd_wdata_q;
   logic              sel_q, rd_q, wr_q, done_q, tmo_q;
   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] wdata_q, rdata_q;

   logic              accept;
   logic              bst_start, bst_last;
   logic [NW-1:0]     bst_n;
   logic              poll_miss, poll_expired;

   assign accept    = (st_q == ST_IDLE) && req_valid;
   assign poll_miss = (st_q == ST_POLL) && !phy_ack && !poll_expired;
   assign bst_start = accept || (st_q == ST_GO) || poll_miss;
   assign bst_n     = (st_q == ST_IDLE) ? NW'(PRE_PULSES) : NW'(1);

   phyport_clk_burst #(
      .PHASE_CYCLES (PHASE_CYCLES),
      .MAX_PULSES   (PRE_PULSES)
   ) u_burst (
      .clk      (clk),
      .rst      (rst),
      .start    (bst_start),
      .n_pulses (bst_n),
      .pclk     (phy_clk),
      .last     (bst_last)
   );

   phyport_poll_ctr #(
      .MAX_POLLS (MAX_POLLS)
   ) u_poll (
      .clk     (clk),
      .rst     (rst),
      .clr     (accept),
      .miss    (poll_miss),
      .expired (poll_expired)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         st_q        <= ST_IDLE;
         cmd_wr_q    <= 1'b0;
         cmd_addr_q  <= '0;
         cmd_wdata_q <= '0;
         sel_q       <= 1'b0;
         rd_q        <= 1'b0;
         wr_q        <= 1'b0;
         done_q      <= 1'b0;
         tmo_q       <= 1'b0;
         addr_q      <= '0;
         wdata_q     <= '0;
         rdata_q     <= '0;
      end else begin
         done_q <= 1'b0;
         tmo_q  <= 1'b0;
         unique case (st_q)
            ST_IDLE: if (req_valid) begin
               cmd_wr_q    <= req_write;
               cmd_addr_q  <= req_addr;
               cmd_wdata_q <= req_wdata;
               st_q        <= ST_PRE;
            end
            ST_PRE:  if (bst_last) st_q <= ST_SEL;
            ST_SEL: begin
               sel_q <= 1'b1;
               st_q  <= ST_ADDR;
            end
            ST_ADDR: begin
               addr_q <= cmd_addr_q;
               st_q   <= cmd_wr_q ? ST_DATA : ST_EN;
            end
            ST_DATA: begin
               wdata_q <= cmd_wdata_q;
               st_q    <= ST_EN;
            end
            ST_EN: begin
               wr_q <= cmd_wr_q;
               rd_q <= !cmd_wr_q;
               st_q <= ST_GO;
            end
            ST_GO:   st_q <= ST_STRB;
            ST_STRB: if (bst_last) begin
               rd_q <= 1'b0;
               wr_q <= 1'b0;
               st_q <= ST_POLL;
            end
            ST_POLL: if (phy_ack) begin
               if (!cmd_wr_q) rdata_q <= phy_rdword[PORT_W-1 -: DATA_W];
               done_q <= 1'b1;
               sel_q  <= 1'b0;
               st_q   <= ST_IDLE;
            end else if (poll_expired) begin
               tmo_q <= 1'b1;
               sel_q <= 1'b0;
               st_q  <= ST_IDLE;
            end else begin
               st_q <= ST_PCLK;
            end
            ST_PCLK: if (bst_last) st_q <= ST_POLL;
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   assign busy        = (st_q != ST_IDLE);
   assign rsp_done    = done_q;
   assign rsp_timeout = tmo_q;
   assign rsp_rdata   = rdata_q;
   assign phy_sel     = sel_q;
   assign phy_addr    = addr_q;
   assign phy_wdata   = wdata_q;
   assign phy_rd_en   = rd_q;
   assign phy_wr_en   = wr_q;

endmodule

// File: rtl/phyport_master_chk.sv
module phyport_master_chk #(
   parameter int ADDR_W       = 16,
   parameter int DATA_W       = 16,
   parameter int PHASE_CYCLES = 2
) (
   input logic              clk,
   input logic              rst,
   input logic              busy,
   input logic              rsp_done,
   input logic              rsp_timeout,
   input logic              phy_clk,
   input logic              phy_sel,
   input logic [ADDR_W-1:0] phy_addr,
   input logic [DATA_W-1:0] phy_wdata,
   input logic              phy_rd_en,
   input logic              phy_wr_en
);

   logic [15:0] hi_run;

   always_ff @(posedge clk) begin
      if (rst || !phy_clk) hi_run <= '0;
      else                 hi_run <= hi_run + 1'b1;
   end

   p_high_phase_r2: assert property (@(posedge clk) disable iff (rst)
      $fell(phy_clk) |-> (hi_run == 16'(PHASE_CYCLES)));

   p_sel_moves_clk_low_r1: assert property (@(posedge clk) disable iff (rst)
      !$stable(phy_sel) |-> (!phy_clk && !$past(phy_clk)));

   p_addr_after_sel_r3: assert property (@(posedge clk) disable iff (rst)
      !$stable(phy_addr) |-> $past(phy_sel));

   p_wdata_first_r3: assert property (@(posedge clk) disable iff (rst)
      $rose(phy_wr_en) |-> ($stable(phy_wdata) && phy_sel));

   p_one_enable_r4: assert property (@(posedge clk) disable iff (rst)
      !(phy_rd_en && phy_wr_en));

   p_enable_rise_low_r4: assert property (@(posedge clk) disable iff (rst)
      ($rose(phy_rd_en) || $rose(phy_wr_en)) |-> !phy_clk);

   p_resp_exclusive_r6: assert property (@(posedge clk) disable iff (rst)
      !(rsp_done && rsp_timeout));

   p_clk_needs_busy_r8: assert property (@(posedge clk) disable iff (rst)
      phy_clk |-> busy);

   p_busy_ends_with_resp_r8: assert property (@(posedge clk) disable iff (rst)
      $fell(busy) |-> (rsp_done || rsp_timeout));

   p_resp_port_quiet_r8: assert property (@(posedge clk) disable iff (rst)
      (rsp_done || rsp_timeout) |-> (!phy_sel && !phy_rd_en && !phy_wr_en));

endmodule

bind phyport_master phyport_master_chk #(
   .ADDR_W       (ADDR_W),
   .DATA_W       (DATA_W),
   .PHASE_CYCLES (PHASE_CYCLES)
) u_chk (
   .clk         (clk),
   .rst         (rst),
   .busy        (busy),
   .rsp_done    (rsp_done),
   .rsp_timeout (rsp_timeout),
   .phy_clk     (phy_clk),
   .phy_sel     (phy_sel),
   .phy_addr    (phy_addr),
   .phy_wdata   (phy_wdata),
   .phy_rd_en   (phy_rd_en),
   .phy_wr_en   (phy_wr_en)
);

// File: tb/tb_phyport_master.sv
module tb_phyport_master;

   localparam int CLK_PERIOD = 10;
   localparam int PRE        = 100;
   localparam int PHASE      = 3;
   localparam int MAXP       = 8;

   typedef struct packed {
      logic        tmo;
      logic        rd;
      logic [15:0] data;
      logic [31:0] extra;
   } exp_t;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        req_valid = 1'b0;
   logic        req_write = 1'b0;
   logic [15:0] req_addr = '0;
   logic [15:0] req_wdata = '0;
   logic        busy, rsp_done, rsp_timeout;
   logic [15:0] rsp_rdata;
   logic        phy_clk, phy_sel, phy_rd_en, phy_wr_en;
   logic [15:0] phy_addr, phy_wdata;
   logic        phy_ack;
   logic [31:0] phy_rdword;

   int checks = 0;
   int errors = 0;
   int resp_cnt = 0;
   exp_t exp_q[$];

   phyport_master #(
      .PHASE_CYCLES (PHASE),
      .MAX_POLLS    (MAXP)
   ) dut (
      .clk (clk), .rst (rst),
      .req_valid (req_valid), .req_write (req_write),
      .req_addr (req_addr), .req_wdata (req_wdata),
      .busy (busy), .rsp_done (rsp_done), .rsp_timeout (rsp_timeout),
      .rsp_rdata (rsp_rdata),
      .phy_clk (phy_clk), .phy_sel (phy_sel), .phy_addr (phy_addr),
      .phy_wdata (phy_wdata), .phy_rd_en (phy_rd_en), .phy_wr_en (phy_wr_en),
      .phy_ack (phy_ack), .phy_rdword (phy_rdword)
   );

   always #(CLK_PERIOD / 2) clk = ~clk;

   // Responder standing in for the PHY register file
   logic [15:0] mem [16] = '{16'h1000, 16'h1001, 16'h1002, 16'h1003,
                             16'h1004, 16'h1005, 16'h1006, 16'h1007,
                             16'h1008, 16'h1009, 16'h100A, 16'h100B,
                             16'h100C, 16'h100D, 16'h100E, 16'h100F};
   logic        pend = 1'b0;
   int unsigned acnt = 0;
   int unsigned ack_delay = 0;

   always @(posedge phy_clk) begin
      if (!phy_sel) begin
         pend <= 1'b0;
      end else if (phy_rd_en || phy_wr_en) begin
         if (phy_wr_en) mem[phy_addr[3:0]] <= phy_wdata;
         pend <= 1'b1;
         acnt <= ack_delay;
      end else if (pend && acnt != 0) begin
         acnt <= acnt - 1;
      end
   end

   assign phy_ack    = pend && (acnt == 0);
   assign phy_rdword = {mem[phy_addr[3:0]], ~phy_addr};

   task automatic chk(input bit ok, input string rq, input string what,
                      input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
      end
   endtask

   // Monitor: pulse accounting and scoreboard comparison
   int   pre_cnt = 0, strb_cnt = 0, post_cnt = 0, hi_len = 0;
   logic prev_pclk = 1'b0;

   always @(negedge clk) begin
      if (rst) begin
         hi_len    = 0;
         prev_pclk = 1'b0;
      end else begin
         if (req_valid && !busy) begin
            pre_cnt = 0; strb_cnt = 0; post_cnt = 0;
         end
         if (phy_clk && !prev_pclk) begin
            if (!phy_sel)                    pre_cnt++;
            else if (phy_rd_en || phy_wr_en) strb_cnt++;
            else                             post_cnt++;
         end
         if (phy_clk) hi_len++;
         else if (hi_len != 0) begin
            chk(hi_len == PHASE, "R2", "high phase length", hi_len, PHASE);
            hi_len = 0;
         end
         if (rsp_done || rsp_timeout) begin
            if (exp_q.size() == 0) begin
               chk(1'b0, "R8", "response with nothing outstanding", 1, 0);
            end else begin
               exp_t e;
               e = exp_q.pop_front();
               chk(rsp_timeout == e.tmo, "R6", "timeout flag", rsp_timeout, e.tmo);
               chk(rsp_done == !e.tmo, "R6", "done flag", rsp_done, !e.tmo);
               chk(pre_cnt == PRE, "R1", "preamble pulses", pre_cnt, PRE);
               chk(strb_cnt == 1, "R4", "strobe pulses", strb_cnt, 1);
               chk(post_cnt == int'(e.extra), e.tmo ? "R6" : "R5",
                   "extra poll pulses", post_cnt, e.extra);
               if (e.rd && !e.tmo)
                  chk(rsp_rdata == e.data, "R7", "read data (upper half)",
                      rsp_rdata, e.data);
            end
            resp_cnt++;
         end
         prev_pclk = phy_clk;
      end
   end

   task automatic issue(input logic w, input logic [15:0] a, input logic [15:0] d,
                        input int unsigned dly, input logic tmo,
                        input logic [15:0] ed, input bit push);
      exp_t e;
      ack_delay = dly;
      if (push) begin
         e.tmo   = tmo;
         e.rd    = !w;
         e.data  = ed;
         e.extra = tmo ? 32'(MAXP - 1) : 32'(dly);
         exp_q.push_back(e);
      end
      @(posedge clk); #1;
      req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d;
      @(posedge clk); #1;
      req_valid = 1'b0;
   endtask

   task automatic inject(input logic w, input logic [15:0] a, input logic [15:0] d);
      @(posedge clk); #1;
      req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d;
      @(posedge clk); #1;
      req_valid = 1'b0;
   endtask

   task automatic wait_resp(input int target);
      while (resp_cnt < target) @(posedge clk);
   endtask

   task automatic access(input logic w, input logic [15:0] a, input logic [15:0] d,
                         input int unsigned dly, input logic tmo, input logic [15:0] ed);
      int target;
      target = resp_cnt + 1;
      issue(w, a, d, dly, tmo, ed, 1'b1);
      wait_resp(target);
      repeat (3) @(posedge clk);
   endtask

   task automatic check_idle(input string rq);
      @(negedge clk);
      chk(phy_clk == 1'b0, rq, "port clock after reset", phy_clk, 0);
      chk(phy_sel == 1'b0, rq, "select after reset", phy_sel, 0);
      chk({phy_rd_en, phy_wr_en} == 2'b00, rq, "enables after reset",
          {phy_rd_en, phy_wr_en}, 0);
      chk(busy == 1'b0, rq, "busy after reset", busy, 0);
      chk({rsp_done, rsp_timeout} == 2'b00, rq, "response pulses after reset",
          {rsp_done, rsp_timeout}, 0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: run did not complete, actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      int target;
      repeat (3) @(posedge clk); #1;
      rst = 1'b0;
      check_idle("R9");

      // R10, R3: write then read back; R7 low half of port word is garbage
      access(1'b1, 16'h0003, 16'hA5C3, 0, 1'b0, 16'h0);
      access(1'b0, 16'h0003, 16'h0000, 0, 1'b0, 16'hA5C3);

      // R5: acknowledge after three extra pulses
      access(1'b1, 16'h0005, 16'h1234, 3, 1'b0, 16'h0);

      // R8: request while busy is dropped
      target = resp_cnt + 1;
      issue(1'b0, 16'h0005, 16'h0000, 1, 1'b0, 16'h1234, 1'b1);
      repeat (20) @(posedge clk);
      @(negedge clk);
      chk(busy == 1'b1, "R8", "busy during access", busy, 1);
      inject(1'b1, 16'h0005, 16'hBEEF);
      wait_resp(target);
      repeat (3) @(posedge clk);
      access(1'b0, 16'h0005, 16'h0000, 0, 1'b0, 16'h1234);

      // R6 boundary: acknowledge on the last allowed sample
      access(1'b0, 16'h0009, 16'h0000, MAXP - 1, 1'b0, 16'h1009);
      // R6: acknowledge never comes
      access(1'b0, 16'h0002, 16'h0000, 1000, 1'b1, 16'h0);
      // recovery after timeout
      access(1'b0, 16'h0002, 16'h0000, 0, 1'b0, 16'h1002);

      // R9: reset in the middle of a write preamble aborts it
      issue(1'b1, 16'h0006, 16'hDEAD, 0, 1'b0, 16'h0, 1'b0);
      repeat (50) @(posedge clk); #1;
      rst = 1'b1;
      repeat (2) @(posedge clk); #1;
      rst = 1'b0;
      check_idle("R9");
      access(1'b0, 16'h0006, 16'h0000, 0, 1'b0, 16'h1006);

      chk(exp_q.size() == 0, "R8", "outstanding responses", exp_q.size(), 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule